// File: doc/BRIEF.md
# Shaped Pulse-Pair Generator

This block drives the transmit path of a pulse ranging system. It emits a repeating train of pulse pairs as a signed 12-bit sample stream for a DAC. Inside each pulse a sine carrier, read from a 4096-entry table, is multiplied by a raised-cosine (sin², the cos² bell centred on the pulse) envelope. The envelope table is stretched over the programmed pulse width, so the whole bell fits into one pulse whatever width is set. Between the pulses the output holds at zero.

A write port programs four settings: the pulse width, the gap between the two pulses of a pair, the gap between pairs, and an enable. All durations are counted in sample slots. One slot is `PRESCALE` clocks, and each slot yields one sample marked by `sample_valid`. Settings written while the block runs are buffered. They move into the sequencer only when a new pair begins. Clearing the enable never cuts a pulse short.

Top module: `shaped_pair_gen`

## Requirements
- R1: After reset, `sample`, `sample_valid` and `pulse_on` are 0, every setting is 0 and enable is clear, and the block emits idle (zero) slots until it is enabled.
- R2: A write (`wr_en` high at a rising edge) uses `wr_sel` to pick the target: 0 = pulse width, 1 = gap inside a pair, 2 = gap between pairs, 3 = enable. For select 3, any nonzero value sets enable and zero clears it.
- R3: `sample_valid` is high for exactly one clock in every `PRESCALE` clocks from reset on, whether the block is enabled or not. `sample` and `pulse_on` change only in the cycles where `sample_valid` is high.
- R4: Slots follow the order first pulse, inside gap, second pulse, between gap, then the first pulse again. Each phase lasts its programmed count of slots, and a count of 0 lasts one slot.
- R5: In every slot outside a pulse (gaps and idle), `sample` is 0 and `pulse_on` is 0. Inside a pulse, `pulse_on` is 1.
- R6: For slot k (from 0) of a pulse of width W: e = E[floor(k·64/max(W,1))] with E[i] = round(2047·sin²(πi/64)); c = S[(k·CAR_STEP) mod 4096] with S[j] = round(2047·sin(2πj/4096)); sample = floor((c·e + 1024)/2048). The first slot of every pulse is therefore 0.
- R7: When enable is set while the block is idle, the first slot after the write is still idle and the next slot is slot 0 of the first pulse.
- R8: If enable is cleared during a pulse, that pulse runs to its full width, then only idle slots follow. If it is cleared during a gap, the next slot is a zero gap slot, then only idle slots follow.
- R9: Settings written while pairs are running take effect from the first pulse of the next pair. The pair in progress keeps the width and gaps it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select (0 width, 1 inside gap, 2 between gap, 3 enable) |
| wr_data | input | CNT_W | Value to write |
| sample | output | 12 | Signed output sample |
| sample_valid | output | 1 | One-clock strobe per slot |
| pulse_on | output | 1 | High for slots that belong to a pulse |

## Verification
On every cycle, the assertions check the following: the strobe is a single clock wide and the sample holds between strobes; the slot counter stays inside the current phase length; the second pulse is entered only from the inside gap; a pulse that ends with enable clear leads to idle; the active settings change only at a pair start; and each pulse opens on a zero sample with a legal envelope index. Only the bench scenarios can show the full waveform. That covers the exact sample values against an independently computed envelope and carrier, the phase lengths with zero counts, the single idle slot after enabling, the two ways of stopping, and a setting change landing exactly at the next pair.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int SMP_W      = 12;
  localparam int FULL_SCALE = 2047;
  localparam real PI        = 3.14159265358979323846;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P1,
    ST_GAP_IN,
    ST_P2,
    ST_GAP_OUT
  } seq_state_t;

  // Round to nearest, halves away from zero.
  function automatic int round_near(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

  // Bell envelope entry i of a table of depth entries.
  function automatic logic signed [SMP_W-1:0] env_coef(input int i, input int depth);
    real s;
    s = $sin(PI * i / depth);
    return SMP_W'(round_near(FULL_SCALE * s * s));
  endfunction

  // Carrier entry j of a table holding one full sine period.
  function automatic logic signed [SMP_W-1:0] car_coef(input int j, input int depth);
    return SMP_W'(round_near(FULL_SCALE * $sin(2.0 * PI * j / depth)));
  endfunction

  // Signed product scaled back to SMP_W bits, rounding half up.
  function automatic logic signed [SMP_W-1:0] scale_mix(input logic signed [SMP_W-1:0] c,
                                                        input logic signed [SMP_W-1:0] e);
    logic signed [2*SMP_W-1:0] p;
    p = c * e;
    p = p + $signed((2*SMP_W)'(1 << (SMP_W - 2)));
    return SMP_W'(p >>> (SMP_W - 1));
  endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pair_start,
  output logic             run_en,
  output logic [CNT_W-1:0] act_width,
  output logic [CNT_W-1:0] act_gap_in,
  output logic [CNT_W-1:0] act_gap_out
);

  logic [CNT_W-1:0] sh_width, sh_gap_in, sh_gap_out;

  // Shadow settings accept writes at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_width   <= '0;
      sh_gap_in  <= '0;
      sh_gap_out <= '0;
      run_en     <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    sh_width   <= wr_data;
        2'd1:    sh_gap_in  <= wr_data;
        2'd2:    sh_gap_out <= wr_data;
        default: run_en     <= (wr_data != '0);
      endcase
    end
  end

  // Active settings move only when a pair begins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_width   <= '0;
      act_gap_in  <= '0;
      act_gap_out <= '0;
    end else if (pair_start) begin
      act_width   <= sh_width;
      act_gap_in  <= sh_gap_in;
      act_gap_out <= sh_gap_out;
    end
  end

  assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_start |=> ($stable(act_width) && $stable(act_gap_in) && $stable(act_gap_out)));

endmodule

// File: rtl/ppg_seq.sv
module ppg_seq
  import ppg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] len_pulse,
  input  logic [CNT_W-1:0] len_gap_in,
  input  logic [CNT_W-1:0] len_gap_out,
  output logic             tick,
  output seq_state_t       state,
  output logic [CNT_W-1:0] slot_cnt,
  output logic             pair_start
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  // Index of the final slot of a phase; a zero length counts as one slot.
  function automatic logic [CNT_W-1:0] last_slot(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - CNT_W'(1);
  endfunction

  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] len_sel, nxt_cnt;
  logic             at_end;
  seq_state_t       nxt_state;

  assign tick = (pre_cnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_comb begin
    case (state)
      ST_P1, ST_P2: len_sel = len_pulse;
      ST_GAP_IN:    len_sel = len_gap_in;
      ST_GAP_OUT:   len_sel = len_gap_out;
      default:      len_sel = '0;
    endcase
  end

  assign at_end = (slot_cnt == last_slot(len_sel));

  always_comb begin
    nxt_state = state;
    nxt_cnt   = slot_cnt + CNT_W'(1);
    case (state)
      ST_IDLE: begin
        nxt_cnt = '0;
        if (run_en) nxt_state = ST_P1;
      end
      ST_P1: if (at_end) begin
        nxt_cnt   = '0;
        nxt_state = run_en ? ST_GAP_IN : ST_IDLE;
      end
      ST_GAP_IN: if (!run_en) begin
        nxt_cnt   = '0;
        nxt_state = ST_IDLE;
      end else if (at_end) begin
        nxt_cnt   = '0;
        nxt_state = ST_P2;
      end
      ST_P2: if (at_end) begin
        nxt_cnt   = '0;
        nxt_state = run_en ? ST_GAP_OUT : ST_IDLE;
      end
      ST_GAP_OUT: if (!run_en) begin
        nxt_cnt   = '0;
        nxt_state = ST_IDLE;
      end else if (at_end) begin
        nxt_cnt   = '0;
        nxt_state = ST_P1;
      end
      default: begin
        nxt_cnt   = '0;
        nxt_state = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot_cnt <= '0;
    end else if (tick) begin
      state    <= nxt_state;
      slot_cnt <= nxt_cnt;
    end
  end

  assign pair_start = tick && (nxt_state == ST_P1) && (state != ST_P1);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (slot_cnt <= last_slot(len_sel)));

  assert_second_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_P2 && $past(state) != ST_P2) |-> ($past(state) == ST_GAP_IN));

  assert_stop_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (state == ST_P1 || state == ST_P2) && at_end && !run_en) |=> (state == ST_IDLE));

endmodule

// File: rtl/ppg_shape.sv
module ppg_shape
  import ppg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ENV_AW   = 6,
  parameter int CAR_AW   = 12,
  parameter int CAR_STEP = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  seq_state_t              state,
  input  logic [CNT_W-1:0]        slot_cnt,
  input  logic [CNT_W-1:0]        width,
  output logic signed [SMP_W-1:0] sample,
  output logic                    sample_valid,
  output logic                    pulse_on
);

  localparam int ENV_DEPTH = 1 << ENV_AW;
  localparam int CAR_DEPTH = 1 << CAR_AW;
  localparam int Q_W       = CNT_W + ENV_AW;

  // Envelope position: elapsed fraction of the pulse scaled to the table depth.
  function automatic logic [Q_W-1:0] env_index(input logic [CNT_W-1:0] k,
                                               input logic [CNT_W-1:0] w);
    logic [Q_W-1:0] num, den;
    num = {k, ENV_AW'(0)};
    den = Q_W'((w == '0) ? CNT_W'(1) : w);
    return num / den;
  endfunction

  // Carrier position: fixed phase step per slot, wrapping over one period.
  function automatic logic [CAR_AW-1:0] car_index(input logic [CNT_W-1:0] k);
    return CAR_AW'(k * CAR_STEP);
  endfunction

  logic signed [SMP_W-1:0] env_rom [ENV_DEPTH];
  logic signed [SMP_W-1:0] car_rom [CAR_DEPTH];

  initial begin
    for (int i = 0; i < ENV_DEPTH; i++) env_rom[i] = env_coef(i, ENV_DEPTH);
    for (int j = 0; j < CAR_DEPTH; j++) car_rom[j] = car_coef(j, CAR_DEPTH);
  end

  logic                    in_pulse;
  logic [Q_W-1:0]          env_full;
  logic [ENV_AW-1:0]       env_idx;
  logic [CAR_AW-1:0]       car_idx;
  logic signed [SMP_W-1:0] mix;

  assign in_pulse = (state == ST_P1) || (state == ST_P2);
  assign env_full = env_index(slot_cnt, width);
  assign env_idx  = env_full[ENV_AW-1:0];
  assign car_idx  = car_index(slot_cnt);
  assign mix      = scale_mix(car_rom[car_idx], env_rom[env_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample       <= '0;
      sample_valid <= 1'b0;
      pulse_on     <= 1'b0;
    end else begin
      sample_valid <= tick;
      if (tick) begin
        sample   <= in_pulse ? mix : '0;
        pulse_on <= in_pulse;
      end
    end
  end

  assert_env_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (env_full < Q_W'(ENV_DEPTH)));

  assert_pulse_opens_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> (sample == '0));

  assert_gap_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !pulse_on) |-> (sample == '0));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(sample) && $stable(pulse_on)));

endmodule

// File: rtl/shaped_pair_gen.sv
module shaped_pair_gen
  import ppg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4,
  parameter int ENV_AW   = 6,
  parameter int CAR_AW   = 12,
  parameter int CAR_STEP = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [CNT_W-1:0]        wr_data,
  output logic signed [SMP_W-1:0] sample,
  output logic                    sample_valid,
  output logic                    pulse_on
);

  logic             run_en, tick, pair_start;
  logic [CNT_W-1:0] act_width, act_gap_in, act_gap_out, slot_cnt;
  seq_state_t       state;

  ppg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .pair_start  (pair_start),
    .run_en      (run_en),
    .act_width   (act_width),
    .act_gap_in  (act_gap_in),
    .act_gap_out (act_gap_out)
  );

  ppg_seq #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .len_pulse   (act_width),
    .len_gap_in  (act_gap_in),
    .len_gap_out (act_gap_out),
    .tick        (tick),
    .state       (state),
    .slot_cnt    (slot_cnt),
    .pair_start  (pair_start)
  );

  ppg_shape #(.CNT_W(CNT_W), .ENV_AW(ENV_AW), .CAR_AW(CAR_AW), .CAR_STEP(CAR_STEP)) u_shape (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .state        (state),
    .slot_cnt     (slot_cnt),
    .width        (act_width),
    .sample       (sample),
    .sample_valid (sample_valid),
    .pulse_on     (pulse_on)
  );

endmodule

// File: tb/test_shaped_pair_gen.sv
module test_shaped_pair_gen;

  localparam int  CNT_W    = 16;
  localparam int  PRESCALE = 4;
  localparam int  CAR_STEP = 64;
  localparam real TPI      = 6.28318530717958647692;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    wr_en = 1'b0;
  logic [1:0]              wr_sel = '0;
  logic [CNT_W-1:0]        wr_data = '0;
  logic signed [11:0]      sample;
  logic                    sample_valid;
  logic                    pulse_on;

  int checks = 0;
  int errors = 0;
  logic signed [11:0] s_smp;
  logic               s_on;

  always #4 clk = ~clk;

  shaped_pair_gen #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .ENV_AW(6), .CAR_AW(12),
                    .CAR_STEP(CAR_STEP)) i_shaped_pair_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sample(sample), .sample_valid(sample_valid), .pulse_on(pulse_on)
  );

  function automatic int rnd(real x);
    return $rtoi($floor(x + 0.5));
  endfunction

  // Expected pulse sample, restated from the requirement text.
  function automatic int exp_sample(int k, int w);
    int we, ei, ci, e, c;
    we = (w == 0) ? 1 : w;
    ei = (k * 64) / we;
    ci = (k * CAR_STEP) % 4096;
    e  = rnd(2047.0 * (1.0 - $cos(TPI * ei / 64.0)) / 2.0);
    c  = rnd(2047.0 * $sin(TPI * ci / 4096.0));
    return $rtoi($floor((c * e) / 2048.0 + 0.5));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_slot();
    do @(negedge clk); while (sample_valid !== 1'b1);
    s_smp = sample;
    s_on  = pulse_on;
  endtask

  task automatic wr(input int sel, input int val);
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = CNT_W'(val);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_pulse(input string req, input int w, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      next_slot();
      check(req, "pulse_on in pulse", int'(s_on), 1);
      check(req, $sformatf("sample k=%0d w=%0d", k, w), int'(s_smp), exp_sample(k, w));
    end
  endtask

  task automatic expect_gap(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      next_slot();
      check(req, "pulse_on in gap", int'(s_on), 0);
      check(req, "sample in gap", int'(s_smp), 0);
    end
  endtask

  task automatic go_idle();
    wr(3, 0);
    do next_slot(); while (s_on);
  endtask

  task automatic configure(input int w, input int g1, input int g2);
    wr(0, w); wr(1, g1); wr(2, g2);
  endtask

  task automatic start(input int en_val);
    next_slot();
    wr(3, en_val);
    expect_gap("R7", 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "sample in reset", int'(sample), 0);
    check("R1", "valid in reset", int'(sample_valid), 0);
    check("R1", "pulse_on in reset", int'(pulse_on), 0);
    rst_n = 1'b1;
    expect_gap("R1", 6);
  endtask

  task automatic t_strobe();
    int gap;
    next_slot();
    @(negedge clk);
    check("R3", "valid width", int'(sample_valid), 0);
    gap = 1;
    while (sample_valid !== 1'b1) begin
      @(negedge clk);
      gap++;
    end
    check("R3", "strobe period", gap, PRESCALE);
  endtask

  task automatic t_basic();
    configure(5, 3, 7);
    start(1);
    expect_pulse("R6", 5, 0, 4);
    expect_gap("R4", 3);
    expect_pulse("R4", 5, 0, 4);
    expect_gap("R5", 7);
    expect_pulse("R4", 5, 0, 4);
    expect_gap("R4", 3);
    go_idle();
  endtask

  task automatic t_mid_write();
    configure(5, 3, 7);
    start(1);
    expect_pulse("R9", 5, 0, 0);
    wr(0, 9);
    wr(2, 2);
    expect_pulse("R9", 5, 1, 4);
    expect_gap("R9", 3);
    expect_pulse("R9", 5, 0, 4);
    expect_gap("R9", 7);
    expect_pulse("R9", 9, 0, 8);
    expect_gap("R9", 3);
    expect_pulse("R9", 9, 0, 8);
    expect_gap("R9", 2);
    expect_pulse("R9", 9, 0, 8);
    go_idle();
  endtask

  task automatic t_stop_in_pulse();
    configure(5, 3, 7);
    start(1);
    expect_pulse("R8", 5, 0, 1);
    wr(3, 0);
    expect_pulse("R8", 5, 2, 4);
    expect_gap("R8", 20);
  endtask

  task automatic t_stop_in_gap();
    configure(4, 5, 3);
    start(1);
    expect_pulse("R8", 4, 0, 3);
    expect_gap("R8", 1);
    wr(3, 0);
    expect_gap("R8", 25);
  endtask

  task automatic t_zero_counts();
    configure(0, 0, 0);
    start(1);
    expect_pulse("R4", 0, 0, 0);
    expect_gap("R4", 1);
    expect_pulse("R4", 0, 0, 0);
    expect_gap("R4", 1);
    expect_pulse("R4", 0, 0, 0);
    go_idle();
  endtask

  task automatic t_enable_value();
    configure(40, 2, 2);
    start(2);
    expect_pulse("R2", 40, 0, 39);
    expect_gap("R2", 2);
    expect_pulse("R2", 40, 0, 39);
    go_idle();
    expect_gap("R2", 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_strobe();
    t_basic();
    t_mid_write();
    t_stop_in_pulse();
    t_stop_in_gap();
    t_zero_counts();
    t_enable_value();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule